// File: doc/BRIEF.md
# I2C slave EEPROM emulator

This block sits behind the byte layer of an I2C target and makes it answer like a small serial EEPROM. The bit engine in front of it reports three bus events (a write-direction start, a read-direction start and a stop) and hands over each received byte. It also requests a byte each time the remote master reads. The block keeps a byte array and an address pointer. The first byte after a write-direction start is taken as the new pointer value. Every later received byte is written at the pointer, and every read fetches from the pointer. In both cases the pointer then advances and wraps at the end of the array.

Local logic can register a number of address windows. When a received byte lands inside any enabled window, the block raises a one-cycle notification that carries the address and the new value. The local side can use this to react to writes into a mailbox or a configuration area without polling the array. A window whose range would run past the end of the array is refused, and the refusal is reported with a one-cycle pulse.

The inputs are expected to arrive one operation per cycle. At most one of the three events, a received byte or a read request is active in any cycle.

Top module: `eeprom_slave_emu`

## Requirements
- R1: After reset the pointer is 0, the first-byte flag is clear, no window is enabled, and `rd_valid`, `notify_valid` and `cfg_reject` are low.
- R2: `ev_wr_start` arms the first-byte flag. The next received byte loads the pointer and is not stored. It never causes a notification. The flag then clears.
- R3: `ev_rd_start` or `ev_stop` clears the first-byte flag, so the next received byte is stored at the current pointer.
- R4: A received byte with the flag clear is written at the pointer, and the pointer then increments modulo 256 (address 255 is followed by 0).
- R5: `rd_req` returns the byte at the pointer on `rd_data`, with `rd_valid` high, in the cycle after the request. The pointer then increments modulo 256. A read-direction start does not move the pointer.
- R6: A `cfg_we` with `cfg_enable` high registers window `cfg_idx` as the inclusive range from `cfg_start` to `cfg_start+cfg_size-1`. If `cfg_size` is 0 or `cfg_start+cfg_size` exceeds 256, the request is refused: `cfg_reject` pulses in the next cycle and the window keeps its previous setting. A `cfg_we` with `cfg_enable` low disables the window.
- R7: A stored byte whose address lies inside any enabled window gives, in the next cycle, a one-cycle `notify_valid` with `notify_addr` and `notify_data` set to that address and byte. Both bounds of the range are inclusive.
- R8: A stored byte outside every enabled window gives no notification.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| ev_wr_start | input | 1 | Bus event: start addressed to this target, write direction |
| ev_rd_start | input | 1 | Bus event: start addressed to this target, read direction |
| ev_stop | input | 1 | Bus event: stop seen |
| rx_valid | input | 1 | A byte was received from the master |
| rx_data | input | DW (8) | Received byte |
| rd_req | input | 1 | Master requests the next byte |
| rd_valid | output | 1 | `rd_data` holds the requested byte |
| rd_data | output | DW (8) | Byte supplied for the master read |
| cfg_we | input | 1 | Window configuration strobe |
| cfg_idx | input | IW (2) | Window index |
| cfg_enable | input | 1 | 1 registers the window, 0 disables it |
| cfg_start | input | AW (8) | First address of the window |
| cfg_size | input | AW+1 (9) | Number of bytes in the window |
| cfg_reject | output | 1 | Pulse: the configuration request was refused |
| notify_valid | output | 1 | Pulse: a byte was stored inside an enabled window |
| notify_addr | output | AW (8) | Address of that byte |
| notify_data | output | DW (8) | Value of that byte |

## Verification
The hardest case to reach from the ports is a store at the highest address that wraps the pointer to zero. A close second is a store on the exact last address of a window. Both need the pointer steered to one chosen address. The stimulus does this with a write-direction start followed by a pointer byte of 0xFF or of the window end. Data bytes then follow, and a second pointer load with a read-direction start reads the bytes back. The same steering shows that the pointer-loading byte is never stored and never notifies. For the check that reset clears the pointer, bytes are sent straight after reset with no start event, and their addresses are read from the notification bus.

// File: rtl/eeprom_emu_pkg.sv
// Shared types for the EEPROM emulator.
// Assumes: nothing beyond standard SystemVerilog.
package eeprom_emu_pkg;

    // Operation performed on the byte array in the current cycle.
    typedef enum logic [1:0] {
        ACT_IDLE     = 2'd0,
        ACT_LOAD_PTR = 2'd1,
        ACT_STORE    = 2'd2,
        ACT_FETCH    = 2'd3
    } action_e;

endpackage

// File: rtl/eeprom_emu_ctrl.sv
// Pointer and first-byte control: decodes bus events, received bytes and
// read requests into an array action, and keeps the address pointer.
// Assumes: at most one of the event, byte and read inputs is active per cycle.
module eeprom_emu_ctrl #(
    parameter int AW = 8,
    parameter int DW = 8
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          ev_wr_start,
    input  logic                          ev_rd_start,
    input  logic                          ev_stop,
    input  logic                          rx_valid,
    input  logic [DW-1:0]                 rx_data,
    input  logic                          rd_req,
    output eeprom_emu_pkg::action_e       action,
    output logic [AW-1:0]                 ptr,
    output logic                          arm
);
    import eeprom_emu_pkg::*;

    // Choose what the array does this cycle.
    always_comb begin
        if (rx_valid)
            action = arm ? ACT_LOAD_PTR : ACT_STORE;
        else if (rd_req)
            action = ACT_FETCH;
        else
            action = ACT_IDLE;
    end

    // First-byte flag: armed by a write start, cleared by the other events or its byte.
    always_ff @(posedge clk) begin
        if (!rst_n)
            arm <= 1'b0;
        else if (ev_wr_start)
            arm <= 1'b1;
        else if (ev_rd_start || ev_stop)
            arm <= 1'b0;
        else if (action == ACT_LOAD_PTR)
            arm <= 1'b0;
    end

    // Address pointer: loaded by the first byte, advanced (wrapping) by stores and reads.
    always_ff @(posedge clk) begin
        if (!rst_n)
            ptr <= '0;
        else begin
            case (action)
                ACT_LOAD_PTR: ptr <= rx_data[AW-1:0];
                ACT_STORE,
                ACT_FETCH:    ptr <= ptr + AW'(1);
                default:      ptr <= ptr;
            endcase
        end
    end

endmodule

// File: rtl/eeprom_emu_mem.sv
// Single-port synchronous byte array with a registered read.
// Assumes: contents are not reset; a read returns data one cycle after en.
module eeprom_emu_mem #(
    parameter int DW    = 8,
    parameter int DEPTH = 256,
    localparam int AW   = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_en,
    input  logic          rd_en,
    input  logic [AW-1:0] addr,
    input  logic [DW-1:0] wdata,
    output logic [DW-1:0] rdata,
    output logic          rvalid
);
    logic [DW-1:0] cells [DEPTH];

    // Array write and registered read.
    always_ff @(posedge clk) begin
        if (wr_en)
            cells[addr] <= wdata;
        if (rd_en)
            rdata <= cells[addr];
    end

    // Read-valid flag, one cycle after a read enable.
    always_ff @(posedge clk) begin
        if (!rst_n)
            rvalid <= 1'b0;
        else
            rvalid <= rd_en;
    end

endmodule

// File: rtl/eeprom_emu_watch.sv
// Address watch windows: stores window registrations with a range check and
// raises a one-cycle notification when a store lands in any enabled window.
// Assumes: DEPTH is a power of two and AW = log2(DEPTH).
module eeprom_emu_watch #(
    parameter int AW    = 8,
    parameter int DW    = 8,
    parameter int NREG  = 4,
    localparam int IW    = (NREG > 1) ? $clog2(NREG) : 1,
    localparam int DEPTH = 1 << AW
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          cfg_we,
    input  logic [IW-1:0] cfg_idx,
    input  logic          cfg_enable,
    input  logic [AW-1:0] cfg_start,
    input  logic [AW:0]   cfg_size,
    output logic          cfg_reject,
    input  logic          store_en,
    input  logic [AW-1:0] store_addr,
    input  logic [DW-1:0] store_data,
    output logic          notify_valid,
    output logic [AW-1:0] notify_addr,
    output logic [DW-1:0] notify_data
);
    logic [AW+1:0] span;
    logic [AW-1:0] last_addr;
    logic          range_bad;
    logic          idx_bad;
    logic [NREG-1:0] hit;

    // Range arithmetic for a registration request.
    always_comb begin
        span      = (AW+2)'(cfg_start) + (AW+2)'(cfg_size);
        last_addr = AW'(span - (AW+2)'(1));
        range_bad = (cfg_size == '0) || (span > (AW+2)'(DEPTH));
        idx_bad   = ({1'b0, cfg_idx} >= (IW+1)'(NREG));
    end

    // Refusal pulse for a bad index or an out-of-range window.
    always_ff @(posedge clk) begin
        if (!rst_n)
            cfg_reject <= 1'b0;
        else
            cfg_reject <= cfg_we && (idx_bad || (cfg_enable && range_bad));
    end

    for (genvar g = 0; g < NREG; g++) begin : g_win
        logic          vld;
        logic [AW-1:0] lo;
        logic [AW-1:0] hi;

        // Window register: enable with accepted range, or disable.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                vld <= 1'b0;
                lo  <= '0;
                hi  <= '0;
            end else if (cfg_we && (cfg_idx == IW'(g))) begin
                if (!cfg_enable)
                    vld <= 1'b0;
                else if (!range_bad) begin
                    vld <= 1'b1;
                    lo  <= cfg_start;
                    hi  <= last_addr;
                end
            end
        end

        // Inclusive range compare for this window.
        assign hit[g] = vld && (store_addr >= lo) && (store_addr <= hi);
    end

    // Notification register: one pulse per store inside any enabled window.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            notify_valid <= 1'b0;
            notify_addr  <= '0;
            notify_data  <= '0;
        end else begin
            notify_valid <= store_en && (|hit);
            if (store_en && (|hit)) begin
                notify_addr <= store_addr;
                notify_data <= store_data;
            end
        end
    end

endmodule

// File: rtl/eeprom_slave_emu.sv
// I2C slave EEPROM emulator top: connects pointer control, byte array and
// watch windows.
// Assumes: one operation input active per cycle; DEPTH is a power of two.
module eeprom_slave_emu #(
    parameter int DEPTH = 256,
    parameter int DW    = 8,
    parameter int NREG  = 4,
    localparam int AW   = $clog2(DEPTH),
    localparam int IW   = (NREG > 1) ? $clog2(NREG) : 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          ev_wr_start,
    input  logic          ev_rd_start,
    input  logic          ev_stop,
    input  logic          rx_valid,
    input  logic [DW-1:0] rx_data,
    input  logic          rd_req,
    output logic          rd_valid,
    output logic [DW-1:0] rd_data,
    input  logic          cfg_we,
    input  logic [IW-1:0] cfg_idx,
    input  logic          cfg_enable,
    input  logic [AW-1:0] cfg_start,
    input  logic [AW:0]   cfg_size,
    output logic          cfg_reject,
    output logic          notify_valid,
    output logic [AW-1:0] notify_addr,
    output logic [DW-1:0] notify_data
);
    import eeprom_emu_pkg::*;

    action_e       action;
    logic [AW-1:0] ptr;
    logic          arm;
    logic          store_en;
    logic          fetch_en;

    // Array strobes derived from the current action.
    assign store_en = (action == ACT_STORE);
    assign fetch_en = (action == ACT_FETCH);

    eeprom_emu_ctrl #(.AW(AW), .DW(DW)) u_ctrl (
        .clk         (clk),
        .rst_n       (rst_n),
        .ev_wr_start (ev_wr_start),
        .ev_rd_start (ev_rd_start),
        .ev_stop     (ev_stop),
        .rx_valid    (rx_valid),
        .rx_data     (rx_data),
        .rd_req      (rd_req),
        .action      (action),
        .ptr         (ptr),
        .arm         (arm)
    );

    eeprom_emu_mem #(.DW(DW), .DEPTH(DEPTH)) u_mem (
        .clk    (clk),
        .rst_n  (rst_n),
        .wr_en  (store_en),
        .rd_en  (fetch_en),
        .addr   (ptr),
        .wdata  (rx_data),
        .rdata  (rd_data),
        .rvalid (rd_valid)
    );

    eeprom_emu_watch #(.AW(AW), .DW(DW), .NREG(NREG)) u_watch (
        .clk          (clk),
        .rst_n        (rst_n),
        .cfg_we       (cfg_we),
        .cfg_idx      (cfg_idx),
        .cfg_enable   (cfg_enable),
        .cfg_start    (cfg_start),
        .cfg_size     (cfg_size),
        .cfg_reject   (cfg_reject),
        .store_en     (store_en),
        .store_addr   (ptr),
        .store_data   (rx_data),
        .notify_valid (notify_valid),
        .notify_addr  (notify_addr),
        .notify_data  (notify_data)
    );

endmodule

// File: rtl/eeprom_emu_chk.sv
// Property checker for the EEPROM emulator, bound to the top module.
// Assumes: observes top-level ports plus the pointer and first-byte flag.
module eeprom_emu_chk #(
    parameter int AW = 8
) (
    input logic          clk,
    input logic          rst_n,
    input logic          ev_wr_start,
    input logic          ev_rd_start,
    input logic          ev_stop,
    input logic          rx_valid,
    input logic          rd_req,
    input logic          rd_valid,
    input logic          cfg_we,
    input logic          cfg_reject,
    input logic          notify_valid,
    input logic          arm,
    input logic [AW-1:0] ptr
);
    // Input contract: one operation per cycle (underpins R2 to R5).
    p_single_op_r4: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({ev_wr_start, ev_rd_start, ev_stop, rx_valid, rd_req}));

    // R2: a write start arms the flag; its byte clears it and never notifies.
    p_arm_set_r2: assert property (@(posedge clk) disable iff (!rst_n)
        ev_wr_start |=> arm);
    p_load_silent_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_valid && arm) |=> (!arm && !notify_valid));

    // R3: read start or stop clears the flag.
    p_arm_clear_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (ev_rd_start || ev_stop) |=> !arm);

    // R4: a stored byte advances the pointer by one, wrapping.
    p_store_inc_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_valid && !arm) |=> (ptr == ($past(ptr) + AW'(1))));

    // R5: read data appears only after a request; a read advances the pointer.
    p_rd_after_req_r5: assert property (@(posedge clk) disable iff (!rst_n)
        rd_valid |-> $past(rd_req));
    p_fetch_inc_r5: assert property (@(posedge clk) disable iff (!rst_n)
        rd_req |=> (ptr == ($past(ptr) + AW'(1))));

    // R6: a refusal only follows a configuration strobe.
    p_reject_cause_r6: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_reject |-> $past(cfg_we));

    // R7: a notification only follows a received byte.
    p_notify_cause_r7: assert property (@(posedge clk) disable iff (!rst_n)
        notify_valid |-> $past(rx_valid));

endmodule

bind eeprom_slave_emu eeprom_emu_chk #(.AW(AW)) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .ev_wr_start  (ev_wr_start),
    .ev_rd_start  (ev_rd_start),
    .ev_stop      (ev_stop),
    .rx_valid     (rx_valid),
    .rd_req       (rd_req),
    .rd_valid     (rd_valid),
    .cfg_we       (cfg_we),
    .cfg_reject   (cfg_reject),
    .notify_valid (notify_valid),
    .arm          (arm),
    .ptr          (ptr)
);

// File: tb/eeprom_slave_emu_test.sv
`timescale 1ns/1ps
module eeprom_slave_emu_test;
    localparam logic [2:0] OP_WS = 3'd0;
    localparam logic [2:0] OP_RS = 3'd1;
    localparam logic [2:0] OP_SP = 3'd2;
    localparam logic [2:0] OP_RX = 3'd3;
    localparam logic [2:0] OP_RD = 3'd4;

    localparam int NV = 26;
    // {op, data, expected read byte}
    localparam logic [18:0] VEC [NV] = '{
        {OP_WS, 8'h00, 8'h00}, {OP_RX, 8'h10, 8'h00}, {OP_RX, 8'hA1, 8'h00},
        {OP_RX, 8'hA2, 8'h00}, {OP_SP, 8'h00, 8'h00}, {OP_WS, 8'h00, 8'h00},
        {OP_RX, 8'h10, 8'h00}, {OP_RS, 8'h00, 8'h00}, {OP_RD, 8'h00, 8'hA1},
        {OP_RD, 8'h00, 8'hA2}, {OP_WS, 8'h00, 8'h00}, {OP_RX, 8'hFF, 8'h00},
        {OP_RX, 8'h5E, 8'h00}, {OP_RX, 8'h6F, 8'h00}, {OP_WS, 8'h00, 8'h00},
        {OP_RX, 8'hFF, 8'h00}, {OP_RS, 8'h00, 8'h00}, {OP_RD, 8'h00, 8'h5E},
        {OP_RD, 8'h00, 8'h6F}, {OP_WS, 8'h00, 8'h00}, {OP_SP, 8'h00, 8'h00},
        {OP_RX, 8'h77, 8'h00}, {OP_WS, 8'h00, 8'h00}, {OP_RX, 8'h01, 8'h00},
        {OP_RS, 8'h00, 8'h00}, {OP_RD, 8'h00, 8'h77}
    };

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       ev_wr_start = 1'b0, ev_rd_start = 1'b0, ev_stop = 1'b0;
    logic       rx_valid = 1'b0;
    logic [7:0] rx_data = '0;
    logic       rd_req = 1'b0;
    logic       rd_valid;
    logic [7:0] rd_data;
    logic       cfg_we = 1'b0;
    logic [1:0] cfg_idx = '0;
    logic       cfg_enable = 1'b0;
    logic [7:0] cfg_start = '0;
    logic [8:0] cfg_size = '0;
    logic       cfg_reject;
    logic       notify_valid;
    logic [7:0] notify_addr;
    logic [7:0] notify_data;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    eeprom_slave_emu uut (
        .clk(clk), .rst_n(rst_n),
        .ev_wr_start(ev_wr_start), .ev_rd_start(ev_rd_start), .ev_stop(ev_stop),
        .rx_valid(rx_valid), .rx_data(rx_data), .rd_req(rd_req),
        .rd_valid(rd_valid), .rd_data(rd_data),
        .cfg_we(cfg_we), .cfg_idx(cfg_idx), .cfg_enable(cfg_enable),
        .cfg_start(cfg_start), .cfg_size(cfg_size), .cfg_reject(cfg_reject),
        .notify_valid(notify_valid), .notify_addr(notify_addr),
        .notify_data(notify_data)
    );

    task automatic chk(input string what, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%0h expected=%0h", what, act, exp);
        end
    endtask

    // One operation for one cycle; returns at the falling edge after it took effect.
    task automatic step(input logic [2:0] op, input logic [7:0] d);
        @(negedge clk);
        ev_wr_start = (op == OP_WS);
        ev_rd_start = (op == OP_RS);
        ev_stop     = (op == OP_SP);
        rx_valid    = (op == OP_RX);
        rx_data     = d;
        rd_req      = (op == OP_RD);
        @(negedge clk);
        ev_wr_start = 1'b0; ev_rd_start = 1'b0; ev_stop = 1'b0;
        rx_valid = 1'b0; rd_req = 1'b0;
    endtask

    task automatic cfg(input logic [1:0] idx, input logic en,
                       input logic [7:0] st, input logic [8:0] sz);
        @(negedge clk);
        cfg_we = 1'b1; cfg_idx = idx; cfg_enable = en;
        cfg_start = st; cfg_size = sz;
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
    endtask

    initial begin
        repeat (3000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual=timeout expected=finish");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        do_reset();
        chk("R1 rd_valid after reset", rd_valid, 0);
        chk("R1 notify_valid after reset", notify_valid, 0);
        chk("R1 cfg_reject after reset", cfg_reject, 0);

        // Table walk: pointer load, store, wrap and read-back (no windows).
        for (int i = 0; i < NV; i++) begin
            step(VEC[i][18:16], VEC[i][15:8]);
            if (VEC[i][18:16] == OP_RD) begin
                chk($sformatf("R5 read valid vec %0d", i), rd_valid, 1);
                chk($sformatf("R5 read data vec %0d (R2 R3 R4)", i), rd_data, VEC[i][7:0]);
            end else if (VEC[i][18:16] == OP_RX) begin
                chk($sformatf("R8 no window no notify vec %0d", i), notify_valid, 0);
            end
        end

        // Directed: reset pointer seen through notifications.
        do_reset();
        chk("R1 notify low after second reset", notify_valid, 0);
        cfg(2'd0, 1'b1, 8'h00, 9'd4);
        chk("R6 accept window 0..3", cfg_reject, 0);
        step(OP_RX, 8'h33);
        chk("R1 pointer zero after reset: notify", notify_valid, 1);
        chk("R1 pointer zero after reset: addr", notify_addr, 8'h00);
        chk("R7 notify data", notify_data, 8'h33);
        step(OP_RX, 8'h34);
        chk("R7 notify addr next", notify_addr, 8'h01);
        step(OP_WS, 8'h00);
        step(OP_RX, 8'h03);
        chk("R2 pointer byte no notify", notify_valid, 0);
        step(OP_RX, 8'h44);
        chk("R7 inclusive end: valid", notify_valid, 1);
        chk("R7 inclusive end: addr", notify_addr, 8'h03);
        step(OP_RX, 8'h45);
        chk("R8 past window end", notify_valid, 0);

        // Read back after reset data.
        step(OP_WS, 8'h00);
        step(OP_RX, 8'h01);
        step(OP_RS, 8'h00);
        step(OP_RD, 8'h00);
        chk("R5 read data at 01", rd_data, 8'h34);
        step(OP_SP, 8'h00);
        chk("R5 rd_valid single cycle", rd_valid, 0);

        // Range limit.
        cfg(2'd1, 1'b1, 8'hF0, 9'h011);
        chk("R6 reject past end", cfg_reject, 1);
        cfg(2'd1, 1'b1, 8'hF0, 9'h010);
        chk("R6 accept up to end", cfg_reject, 0);
        step(OP_WS, 8'h00);
        step(OP_RX, 8'hFF);
        step(OP_RX, 8'h99);
        chk("R7 top address notify", notify_valid, 1);
        chk("R7 top address addr", notify_addr, 8'hFF);
        chk("R7 top address data", notify_data, 8'h99);

        // Refused request keeps earlier window.
        cfg(2'd2, 1'b1, 8'h20, 9'd2);
        chk("R6 accept window 20..21", cfg_reject, 0);
        cfg(2'd2, 1'b1, 8'hFF, 9'd2);
        chk("R6 reject wrap window", cfg_reject, 1);
        cfg(2'd2, 1'b1, 8'h05, 9'd0);
        chk("R6 reject zero size", cfg_reject, 1);
        step(OP_WS, 8'h00);
        step(OP_RX, 8'h21);
        chk("R2 pointer byte inside window no notify", notify_valid, 0);
        step(OP_RX, 8'h5A);
        chk("R6 kept window notify", notify_valid, 1);
        chk("R6 kept window addr", notify_addr, 8'h21);

        // Disable.
        cfg(2'd0, 1'b0, 8'h00, 9'd0);
        chk("R6 disable not refused", cfg_reject, 0);
        step(OP_WS, 8'h00);
        step(OP_RX, 8'h00);
        step(OP_RX, 8'h11);
        chk("R6 disabled window silent", notify_valid, 0);

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule